// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block divides a 32.768 kHz reference tick down to a programmable periodic event. A register block outside it owns a 4-bit rate field and a periodic-enable bit. Each time software writes either one, the register block pulses the matching write strobe. The divider then takes the new value into its own shadow copy, re-evaluates its configuration and restarts its tick count. Each time the period expires, it emits a one-clock event pulse together with the status-flag set mask. The register block ORs that mask into its status register.

The rate field does not map linearly onto the period. Codes 3 to 15 divide by 2^(code-1) reference ticks. Codes 1 and 2 alias upward to the divisors of codes 8 and 9. Code 0 stops the divider, just as a cleared enable does. Only clocks that carry a reference tick advance the count, so the bench and the system may space the ticks as they like.

Top module: `periodic_irq_divider`

## Requirements
- R1: While the shadow enable is 0, or the shadow rate code is 0, no event pulse is produced and `flagSet` stays 0.
- R2: Rate code 1 gives a period of 128 reference ticks and rate code 2 gives a period of 256 reference ticks, the same as codes 8 and 9.
- R3: Rate codes 3 to 15 give a period of 2^(code-1) reference ticks between consecutive event pulses, from 4 ticks for code 3 up to 16384 ticks for code 15.
- R4: In every cycle where `eventPulse` is 1, `flagSet` is 8'hC0, setting status bits 7 (master) and 6 (periodic). In all other cycles `flagSet` is 8'h00.
- R5: A pulse on `rateWr` or `enableWr` restarts the tick count from zero. A reference tick in the same cycle as the write is not counted. The first event then follows exactly one full period of the new configuration later.
- R6: After reset the shadow rate code is 6 and the shadow enable is 0, so no events occur. Writing only the enable to 1 then gives a 32-tick period.
- R7: The event pulse is registered. It is high for exactly one clock, in the cycle after the clock edge that carried the period's last reference tick.
- R8: Clock cycles without `refTick` do not advance the count, so the period in reference ticks does not depend on how the ticks are spaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| refTick | input | 1 | One-cycle strobe per 32.768 kHz reference tick |
| rateCode | input | 4 | Rate field value, taken when `rateWr` is high |
| rateWr | input | 1 | Rate field write strobe |
| irqEnable | input | 1 | Periodic-enable value, taken when `enableWr` is high |
| enableWr | input | 1 | Periodic-enable write strobe |
| eventPulse | output | 1 | One-cycle periodic event |
| flagSet | output | 8 | Status flag set mask, 8'hC0 with each event |

## Verification
A write takes effect at the clock edge that samples its strobe. An event shows up one cycle after the edge that carried the last tick of the period, so the bench numbers each driven reference tick. It samples the outputs at the falling edge after each rising edge. An event seen at that sample belongs to the tick count reached so far, so the first event after a write must be seen at exactly P ticks and the next one at 2P. The bench also drives a tick in the same cycle as every write, which checks that this tick is discarded. A sparse-tick run checks that only ticked clocks are counted.

// File: rtl/pid_pkg.sv
package pid_pkg;
  parameter int RATE_W = 4;
  // largest divisor is 2^(2^RATE_W - 2), so the terminal count needs this many bits
  localparam int CNT_W = (1 << RATE_W) - 2;
  parameter int FLAG_W = 8;

  typedef struct packed {
    logic             restart;
    logic             run;
    logic [CNT_W-1:0] lastCount;
  } ctrlStrobes_t;
endpackage

// File: rtl/pid_ctrl.sv
module pid_ctrl
  import pid_pkg::*;
#(
  parameter int RESET_RATE  = 6,
  parameter int ALIAS_LIMIT = 2,
  parameter int ALIAS_STEP  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              rateWr,
  input  logic              irqEnable,
  input  logic              enableWr,
  output ctrlStrobes_t      strobes
);
  logic [RATE_W-1:0] rateShadow;
  logic              enableShadow;
  logic [RATE_W-1:0] effCode;
  logic [CNT_W:0]    divisor;

  always_ff @(posedge clk) begin
    if (rst) begin
      rateShadow   <= RATE_W'(RESET_RATE);
      enableShadow <= 1'b0;
    end else begin
      if (rateWr)   rateShadow   <= rateCode;
      if (enableWr) enableShadow <= irqEnable;
    end
  end

  // low nonzero codes alias upward before the power-of-two decode
  always_comb begin
    if (rateShadow != '0 && rateShadow <= RATE_W'(ALIAS_LIMIT))
      effCode = rateShadow + RATE_W'(ALIAS_STEP);
    else
      effCode = rateShadow;
    if (effCode == '0)
      divisor = '0;
    else
      divisor = (CNT_W + 1)'(1) << (effCode - RATE_W'(1));
  end

  always_comb begin
    strobes.restart   = rateWr | enableWr;
    strobes.run       = enableShadow & (rateShadow != '0);
    strobes.lastCount = CNT_W'(divisor - (CNT_W + 1)'(1));
  end

  AST_MIN_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    strobes.run |-> strobes.lastCount >= CNT_W'(3)) else $error("min divisor"); // R3
  AST_ALIAS_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (strobes.run && rateShadow == RATE_W'(1)) |-> strobes.lastCount == CNT_W'(127)) else $error("alias"); // R2
endmodule

// File: rtl/pid_datapath.sv
module pid_datapath
  import pid_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         refTick,
  input  ctrlStrobes_t strobes,
  output logic         eventPulse
);
  logic [CNT_W-1:0] tickCount;
  logic             terminal;

  assign terminal = strobes.run & refTick & (tickCount == strobes.lastCount);

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCount  <= '0;
      eventPulse <= 1'b0;
    end else if (strobes.restart) begin
      tickCount  <= '0;
      eventPulse <= 1'b0;
    end else begin
      eventPulse <= terminal;
      if (strobes.run && refTick)
        tickCount <= terminal ? '0 : tickCount + CNT_W'(1);
    end
  end

  AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !strobes.run |=> !eventPulse) else $error("stopped"); // R1
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst)
    strobes.restart |=> !eventPulse) else $error("restart"); // R5
  AST_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    eventPulse |=> !eventPulse) else $error("wide"); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    strobes.run |-> tickCount <= strobes.lastCount) else $error("bound"); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!refTick && !strobes.restart) |=> $stable(tickCount)) else $error("hold"); // R8
endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider
  import pid_pkg::*;
#(
  parameter int               RESET_RATE = 6,
  parameter logic [FLAG_W-1:0] FLAG_MASK = 8'hC0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refTick,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              rateWr,
  input  logic              irqEnable,
  input  logic              enableWr,
  output logic              eventPulse,
  output logic [FLAG_W-1:0] flagSet
);
  ctrlStrobes_t strobes;

  pid_ctrl #(.RESET_RATE(RESET_RATE)) ctrl_i (
    .clk(clk), .rst(rst), .rateCode(rateCode), .rateWr(rateWr),
    .irqEnable(irqEnable), .enableWr(enableWr), .strobes(strobes)
  );

  pid_datapath dp_i (
    .clk(clk), .rst(rst), .refTick(refTick), .strobes(strobes),
    .eventPulse(eventPulse)
  );

  assign flagSet = eventPulse ? FLAG_MASK : '0;

  AST_FLAG_WITH_EVENT: assert property (@(posedge clk) disable iff (rst)
    (flagSet != '0) |-> (eventPulse && flagSet == FLAG_MASK)) else $error("flag"); // R4
endmodule

// File: tb/periodic_irq_divider_tb_top.sv
module periodic_irq_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       refTick = 1'b0;
  logic [3:0] rateCode = 4'd0;
  logic       rateWr = 1'b0;
  logic       irqEnable = 1'b0;
  logic       enableWr = 1'b0;
  logic       eventPulse;
  logic [7:0] flagSet;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  periodic_irq_divider dut_i (
    .clk(clk), .rst(rst), .refTick(refTick), .rateCode(rateCode), .rateWr(rateWr),
    .irqEnable(irqEnable), .enableWr(enableWr), .eventPulse(eventPulse), .flagSet(flagSet)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // write at a negedge, with a coincident reference tick that must be ignored (R5)
  task automatic doWrite(input bit wrRate, input bit wrEn, input int code, input bit en);
    @(negedge clk);
    rateWr = wrRate; enableWr = wrEn; rateCode = 4'(code); irqEnable = en; refTick = 1'b1;
    @(negedge clk);
    rateWr = 1'b0; enableWr = 1'b0; refTick = 1'b0;
  endtask

  // drive maxTicks ticks spaced gap cycles apart; record tick index of events
  task automatic measure(input int maxTicks, input int gap, output int firstAt,
                         output int secondAt, output int evCount, output int badFlag,
                         output int wide);
    int tickCount = 0;
    int cyc = 0;
    bit prevEv = 0;
    firstAt = -1; secondAt = -1; evCount = 0; badFlag = 0; wide = 0;
    while (tickCount <= maxTicks) begin
      @(negedge clk);
      if (eventPulse) begin
        evCount++;
        if (firstAt < 0) firstAt = tickCount;
        else if (secondAt < 0) secondAt = tickCount;
        if (flagSet !== 8'hC0) badFlag++;
        if (prevEv) wide++;
      end else if (flagSet !== 8'h00) badFlag++;
      prevEv = eventPulse;
      if (tickCount == maxTicks) break;
      refTick = ((cyc % gap) == 0);
      if (refTick) tickCount++;
      cyc++;
    end
    refTick = 1'b0;
  endtask

  task automatic testReset();
    int f, s, n, b, w;
    @(negedge clk);
    check("R6 reset eventPulse", int'(eventPulse), 0);
    check("R6 reset flagSet", int'(flagSet), 0);
    measure(100, 1, f, s, n, b, w);
    check("R6 disabled after reset", n, 0);
    doWrite(0, 1, 0, 1);
    measure(64, 1, f, s, n, b, w);
    check("R6 default rate first", f, 32);
    check("R6 default rate second", s, 64);
  endtask

  task automatic testCode(input int code, input int period, input string req);
    int f, s, n, b, w;
    doWrite(1, 1, code, 1);
    measure(2 * period, 1, f, s, n, b, w);
    check($sformatf("%s code %0d first", req, code), f, period);
    check($sformatf("%s code %0d second", req, code), s, 2 * period);
    check($sformatf("%s code %0d count", req, code), n, 2);
    check($sformatf("R4 code %0d flags", code), b, 0);
    check($sformatf("R7 code %0d width", code), w, 0);
  endtask

  task automatic testStopped();
    int f, s, n, b, w;
    doWrite(1, 1, 0, 1);
    measure(300, 1, f, s, n, b, w);
    check("R1 code 0 silent", n, 0);
    check("R1 code 0 flags", b, 0);
    doWrite(1, 1, 3, 0);
    measure(50, 1, f, s, n, b, w);
    check("R1 enable 0 silent", n, 0);
    doWrite(1, 1, 4, 1);
    measure(5, 1, f, s, n, b, w);
    doWrite(0, 1, 0, 0);
    measure(40, 1, f, s, n, b, w);
    check("R1 disable mid period", n, 0);
    doWrite(0, 1, 0, 1);
    measure(16, 1, f, s, n, b, w);
    check("R5 enable write keeps rate 4", f, 8);
  endtask

  task automatic testRestart();
    int f, s, n, b, w;
    doWrite(1, 1, 5, 1);
    measure(10, 1, f, s, n, b, w);
    check("R5 no early event", n, 0);
    doWrite(1, 0, 5, 1);
    measure(32, 1, f, s, n, b, w);
    check("R5 restart full period", f, 16);
    check("R5 restart second", s, 32);
  endtask

  task automatic testSparse();
    int f, s, n, b, w;
    doWrite(1, 1, 3, 1);
    measure(8, 3, f, s, n, b, w);
    check("R8 sparse first", f, 4);
    check("R8 sparse second", s, 8);
    check("R7 sparse width", w, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testStopped();
    testRestart();
    testSparse();
    testCode(1, 128, "R2");
    testCode(2, 256, "R2");
    for (int c = 3; c < 16; c++) testCode(c, 1 << (c - 1), "R3");
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule